// File: doc/BRIEF.md
# Burst Bus Cycle Completion Tracker

This block is the master-side sequencer of a processor-style external bus. A request (start address, read/write, burst or single) is taken when the block is idle. The block then runs one bus cycle. It drives a one-clock address strobe and the current beat address. It watches two active-low ready inputs: a per-cycle ready and a per-beat burst ready. From these it decides when each data transfer completes and when the whole cycle is over.

A burst cycle is a fixed number of beats long. The block counts completed beats, moves the beat address by one data-bus width per beat, and pulls its active-low last-beat output low in the clock where the final beat is expected. The ready inputs are ignored while the bus is idle and in the first clock of every cycle. A per-cycle ready seen together with a burst ready ends a burst at once and is reported as an abort when it comes before the final beat. Each completed transfer gives a one-clock data strobe with its beat index and address. The end of the cycle gives a one-clock done pulse with an aborted flag.

The last-beat output and the address output each have an enable. The last-beat enable drops while the bus is granted away. The address enable also drops while the address-hold input is active. Readies keep completing beats during address hold.

Top module: `bcyc_tracker`

## Requirements
- R1: After reset the block is idle: req_ready=1, bus_ads_n=1, blast_n=1, beat_strobe=0, cyc_done=0, cyc_aborted=0.
- R2: A request seen with req_ready=1 at a clock edge starts a cycle. bus_ads_n is 0 for exactly the next clock, and bus_addr equals req_addr during that clock.
- R3: rdy_n and brdy_n sampled in the first clock of a cycle (the clock with bus_ads_n=0) are ignored: no beat_strobe and no cyc_done follow.
- R4: In a single cycle (req_burst=0), blast_n is 0 from the first clock on. brdy_n is ignored. The first rdy_n=0 sampled after the first clock gives beat_strobe=1 and cyc_done=1 with cyc_aborted=0 in the next clock, with beat_idx=0 and beat_addr equal to the start address.
- R5: In a burst cycle, each clock after the first in which brdy_n=0 and rdy_n=1 completes one beat. It gives beat_strobe=1 in the next clock with beat_idx counting 0,1,2,3. The 4th beat also gives cyc_done=1, cyc_aborted=0. A clock with both readies high completes nothing.
- R6: In a burst, blast_n is 1 until three beats have completed, and 0 while the 4th beat is awaited.
- R7: Each completed beat advances bus_addr by 4 bytes (DBUS_BYTES). beat_addr reports the address of the beat just completed.
- R8: In a burst, rdy_n=0 sampled in a data clock ends the cycle whatever brdy_n is. That clock's transfer is strobed, and cyc_done=1 follows. cyc_aborted=1 if fewer than three beats had completed before it, else 0.
- R9: blast_oe is 0 whenever bus_hold=1 and 1 otherwise.
- R10: While ahold=1, bus_addr_oe is 0, yet ready inputs still complete beats as in R5.
- R11: From acceptance until cyc_done, req_ready=0 and further requests are ignored (no new bus_ads_n pulse). req_ready returns to 1 in the clock that shows cyc_done.
- R12: While the bus is idle, rdy_n and brdy_n have no effect: no beat_strobe, no cyc_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Start address of the cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst cycle, 0 = single |
| req_ready | output | 1 | Idle, a request would be taken |
| bus_ads_n | output | 1 | Active-low address strobe, first clock of a cycle |
| bus_addr | output | ADDR_W | Address of the beat in progress |
| bus_addr_oe | output | 1 | Enable for bus_addr |
| bus_write | output | 1 | Direction of the current cycle |
| rdy_n | input | 1 | Active-low per-cycle ready |
| brdy_n | input | 1 | Active-low burst beat ready |
| blast_n | output | 1 | Active-low: next completion ends the cycle |
| blast_oe | output | 1 | Enable for blast_n |
| ahold | input | 1 | Address hold |
| bus_hold | input | 1 | Bus granted to another master |
| beat_strobe | output | 1 | One transfer completed |
| beat_idx | output | CNT_W | Index of the completed beat |
| beat_addr | output | ADDR_W | Address of the completed beat |
| cyc_done | output | 1 | Cycle ended |
| cyc_aborted | output | 1 | Burst ended early by rdy_n |

## Verification
The hardest case to reach is the early-abort boundary. rdy_n must arrive together with brdy_n partway through a burst, and again exactly on the final beat, where the same stimulus must not raise the aborted flag. The directed tasks reach these states by counting completed beats with brdy_n held low before dropping rdy_n. They also hold both readies low through the first clock to show those samples are discarded. Address hold is raised between beats in mid-burst to show that beats keep completing while the address enable is off.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_DATA  = 2'd2
   } bcyc_state_e;
endpackage

// File: rtl/bcyc_beat_ctr.sv
module bcyc_beat_ctr #(
   parameter int ADDR_W      = 32,
   parameter int DBUS_BYTES  = 4,
   parameter int BURST_BEATS = 4,
   parameter int CNT_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              advance,
   output logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(DBUS_BYTES);
   localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(BURST_BEATS - 1);

   assign last = (cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         addr <= '0;
      end else if (load) begin
         cnt  <= '0;
         addr <= load_addr;
      end else if (advance && !last) begin
         cnt  <= cnt + 1'b1;
         addr <= addr + STEP;
      end
   end
endmodule

// File: rtl/bcyc_seq.sv
module bcyc_seq
   import bcyc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_burst,
   input  logic        rdy_n,
   input  logic        brdy_n,
   input  logic        last_beat,
   output bcyc_state_e state,
   output logic        burst_q,
   output logic        take,
   output logic        beat_now,
   output logic        end_now,
   output logic        abort_now
);
   logic sampling, rdy_hit, brdy_hit;

   assign take      = (state == ST_IDLE) && req_valid;
   assign sampling  = (state == ST_DATA);
   assign rdy_hit   = sampling && !rdy_n;
   assign brdy_hit  = sampling && burst_q && !brdy_n && rdy_n;
   assign beat_now  = rdy_hit || brdy_hit;
   assign end_now   = rdy_hit || (brdy_hit && last_beat);
   assign abort_now = rdy_hit && burst_q && !last_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         burst_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (take) begin
               state   <= ST_FIRST;
               burst_q <= req_burst;
            end
            ST_FIRST: state <= ST_DATA;
            ST_DATA:  if (end_now) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bcyc_tracker.sv
module bcyc_tracker
   import bcyc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DBUS_BYTES  = 4,
   parameter int BURST_BEATS = 4,
   parameter int CNT_W       = $clog2(BURST_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_burst,
   output logic              req_ready,
   output logic              bus_ads_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_addr_oe,
   output logic              bus_write,
   input  logic              rdy_n,
   input  logic              brdy_n,
   output logic              blast_n,
   output logic              blast_oe,
   input  logic              ahold,
   input  logic              bus_hold,
   output logic              beat_strobe,
   output logic [CNT_W-1:0]  beat_idx,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              cyc_done,
   output logic              cyc_aborted
);
   initial begin
      assert (BURST_BEATS >= 2) else $error("BURST_BEATS must be at least 2");
      assert (DBUS_BYTES >= 1)  else $error("DBUS_BYTES must be at least 1");
      assert ((1 << CNT_W) >= BURST_BEATS) else $error("CNT_W too narrow");
   end

   bcyc_state_e       state;
   logic              burst_q, take, beat_now, end_now, abort_now, last;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr;

   bcyc_seq seq_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
      .rdy_n(rdy_n), .brdy_n(brdy_n), .last_beat(last),
      .state(state), .burst_q(burst_q), .take(take), .beat_now(beat_now),
      .end_now(end_now), .abort_now(abort_now)
   );

   bcyc_beat_ctr #(
      .ADDR_W(ADDR_W), .DBUS_BYTES(DBUS_BYTES),
      .BURST_BEATS(BURST_BEATS), .CNT_W(CNT_W)
   ) ctr_i (
      .clk(clk), .rst_n(rst_n), .load(take), .load_addr(req_addr),
      .advance(beat_now), .cnt(cnt), .addr(addr), .last(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_write <= 1'b0;
      end else if (take) begin
         bus_write <= req_write;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_strobe <= 1'b0;
         beat_idx    <= '0;
         beat_addr   <= '0;
         cyc_done    <= 1'b0;
         cyc_aborted <= 1'b0;
      end else begin
         beat_strobe <= beat_now;
         cyc_done    <= end_now;
         cyc_aborted <= abort_now;
         if (beat_now) begin
            beat_idx  <= cnt;
            beat_addr <= addr;
         end
      end
   end

   assign req_ready   = (state == ST_IDLE);
   assign bus_ads_n   = (state != ST_FIRST);
   assign bus_addr    = addr;
   assign bus_addr_oe = !(ahold || bus_hold);
   assign blast_n     = !((state != ST_IDLE) && (!burst_q || last));
   assign blast_oe    = !bus_hold;
endmodule

// File: rtl/bcyc_tracker_chk.sv
module bcyc_tracker_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic bus_ads_n,
   input logic blast_oe,
   input logic bus_hold,
   input logic beat_strobe,
   input logic cyc_done,
   input logic cyc_aborted
);
   // R2
   ads_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ads_n |=> bus_ads_n);

   // R3
   first_clock_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ads_n |=> !beat_strobe);

   // R12
   idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && bus_ads_n) |=> (!beat_strobe || !$past(req_ready)));

   // R8
   abort_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_aborted |-> (cyc_done && beat_strobe));

   // R11
   done_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> req_ready);

   // R9
   blast_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_hold |-> !blast_oe);
endmodule

bind bcyc_tracker bcyc_tracker_chk chk_i (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_ads_n(bus_ads_n),
   .blast_oe(blast_oe), .bus_hold(bus_hold), .beat_strobe(beat_strobe),
   .cyc_done(cyc_done), .cyc_aborted(cyc_aborted)
);

// File: tb/bcyc_tracker_tb.sv
module bcyc_tracker_tb_top;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic rdy_n = 1'b1, brdy_n = 1'b1, ahold = 1'b0, bus_hold = 1'b0;
   logic req_ready, bus_ads_n, bus_addr_oe, bus_write, blast_n, blast_oe;
   logic beat_strobe, cyc_done, cyc_aborted;
   logic [AW-1:0] bus_addr, beat_addr;
   logic [1:0] beat_idx;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   bcyc_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_burst(req_burst), .req_ready(req_ready),
      .bus_ads_n(bus_ads_n), .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
      .bus_write(bus_write), .rdy_n(rdy_n), .brdy_n(brdy_n), .blast_n(blast_n),
      .blast_oe(blast_oe), .ahold(ahold), .bus_hold(bus_hold),
      .beat_strobe(beat_strobe), .beat_idx(beat_idx), .beat_addr(beat_addr),
      .cyc_done(cyc_done), .cyc_aborted(cyc_aborted)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk(input string tag, input longint act, input longint exp);
      check(act == exp, tag, act, exp);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Leaves the bench at the negedge inside the first clock of the cycle.
   task automatic start(input logic [AW-1:0] a, input logic wr, input logic bu);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_burst = bu;
      step();
      req_valid = 1'b0;
      chk("R2 ads_n low in first clock", bus_ads_n, 0);
      chk("R2 address in first clock", bus_addr, a);
      chk("R11 busy after accept", req_ready, 0);
   endtask

   task automatic t_reset();
      chk("R1 req_ready", req_ready, 1);
      chk("R1 ads_n", bus_ads_n, 1);
      chk("R1 blast_n", blast_n, 1);
      chk("R1 strobe", beat_strobe, 0);
      chk("R1 done", cyc_done, 0);
      chk("R1 aborted", cyc_aborted, 0);
   endtask

   task automatic t_idle_ready();
      rdy_n = 1'b0; brdy_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R12 idle strobe", beat_strobe, 0);
         chk("R12 idle done", cyc_done, 0);
         chk("R12 idle ads_n", bus_ads_n, 1);
      end
      rdy_n = 1'b1; brdy_n = 1'b1;
      step();
   endtask

   task automatic t_single();
      start(32'h0000_1000, 1'b1, 1'b0);
      chk("R4 blast_n low in single", blast_n, 0);
      brdy_n = 1'b0; rdy_n = 1'b0;
      step();
      chk("R3 first-clock readies ignored", beat_strobe, 0);
      chk("R2 ads_n one clock only", bus_ads_n, 1);
      rdy_n = 1'b1;
      step();
      chk("R4 brdy ignored in single", beat_strobe, 0);
      chk("R4 no done on brdy", cyc_done, 0);
      brdy_n = 1'b1; rdy_n = 1'b0;
      step();
      rdy_n = 1'b1;
      chk("R4 strobe", beat_strobe, 1);
      chk("R4 done", cyc_done, 1);
      chk("R4 not aborted", cyc_aborted, 0);
      chk("R4 beat_addr", beat_addr, 32'h0000_1000);
      chk("R11 ready with done", req_ready, 1);
      step();
      chk("R4 done is one clock", cyc_done, 0);
   endtask

   task automatic t_burst();
      logic [AW-1:0] a = 32'h0000_2040;
      start(a, 1'b0, 1'b1);
      chk("R6 blast_n high in first clock", blast_n, 1);
      brdy_n = 1'b0;
      step();
      chk("R3 first-clock brdy ignored", beat_strobe, 0);
      chk("R6 blast_n high at beat 0", blast_n, 1);
      step();
      chk("R5 beat0 strobe", beat_strobe, 1);
      chk("R5 beat0 idx", beat_idx, 0);
      chk("R7 beat0 addr", beat_addr, a);
      chk("R7 next addr", bus_addr, a + 4);
      brdy_n = 1'b1; ahold = 1'b1;
      step();
      chk("R5 wait clock no strobe", beat_strobe, 0);
      chk("R10 addr_oe off in ahold", bus_addr_oe, 0);
      brdy_n = 1'b0;
      step();
      chk("R10 beat during ahold", beat_strobe, 1);
      chk("R5 beat1 idx", beat_idx, 1);
      chk("R6 blast_n high after 2 beats", blast_n, 1);
      ahold = 1'b0;
      step();
      chk("R5 beat2 idx", beat_idx, 2);
      chk("R6 blast_n low for last beat", blast_n, 0);
      chk("R10 addr_oe back", bus_addr_oe, 1);
      step();
      brdy_n = 1'b1;
      chk("R5 beat3 idx", beat_idx, 3);
      chk("R5 done after 4 beats", cyc_done, 1);
      chk("R5 not aborted", cyc_aborted, 0);
      chk("R7 last beat addr", beat_addr, a + 12);
      chk("R11 ready again", req_ready, 1);
      step();
   endtask

   task automatic t_abort();
      logic [AW-1:0] b = 32'h0000_3000;
      start(b, 1'b1, 1'b1);
      step();
      chk("R8 bus_write latched", bus_write, 1);
      brdy_n = 1'b0;
      step();
      chk("R8 beat0 before abort", beat_idx, 0);
      rdy_n = 1'b0;
      step();
      rdy_n = 1'b1; brdy_n = 1'b1;
      chk("R8 abort strobe", beat_strobe, 1);
      chk("R8 abort idx", beat_idx, 1);
      chk("R8 abort done", cyc_done, 1);
      chk("R8 aborted flag", cyc_aborted, 1);
      chk("R8 abort addr", beat_addr, b + 4);
      step();
      // rdy_n together with brdy_n on the final beat: not an abort
      start(b, 1'b0, 1'b1);
      brdy_n = 1'b0;
      step();
      step(); step(); step();
      chk("R8 three beats done", beat_idx, 2);
      rdy_n = 1'b0;
      step();
      rdy_n = 1'b1; brdy_n = 1'b1;
      chk("R8 last-beat rdy done", cyc_done, 1);
      chk("R8 last-beat rdy not aborted", cyc_aborted, 0);
      chk("R8 last-beat idx", beat_idx, 3);
      step();
   endtask

   task automatic t_hold();
      bus_hold = 1'b1;
      step();
      chk("R9 blast_oe off in hold", blast_oe, 0);
      chk("R10 addr_oe off in hold", bus_addr_oe, 0);
      bus_hold = 1'b0;
      step();
      chk("R9 blast_oe back", blast_oe, 1);
   endtask

   task automatic t_busy();
      logic [AW-1:0] d = 32'h0000_4000;
      start(d, 1'b0, 1'b1);
      req_valid = 1'b1; req_addr = 32'h0000_9990;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R11 no new ads while busy", bus_ads_n, 1);
         chk("R11 still busy", req_ready, 0);
      end
      req_valid = 1'b0;
      brdy_n = 1'b0;
      step(); step(); step(); step();
      brdy_n = 1'b1;
      chk("R11 done of first request", cyc_done, 1);
      chk("R11 addr of first request", beat_addr, d + 12);
      step();
      chk("R11 no restart", bus_ads_n, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_idle_ready();
      t_single();
      t_burst();
      t_abort();
      t_hold();
      t_busy();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule